// File: doc/BRIEF.md
# Input Overvoltage Fault Supervisor

This block compares each digitized input-voltage sample with a programmable overvoltage threshold. When a sample rises above that threshold, it switches the power switch off. Once the input has dropped below a lower threshold, the switch turns back on by itself. The gap between the two thresholds is a fixed hysteresis band. One fault event also sets a group of status bits in status registers laid out in the PMBus style. Those bits stay set after the input recovers, and only an explicit clear-faults strobe releases them.

The host programs a 4-bit threshold code through a 16-bit register. A write reaches that register only while the write-protect state reports it as unlocked. An active-low alert line and a power-good pin follow the fault. Whether each pin is used depends on mask inputs and on how the two general-purpose pins are configured.

Samples are in units of 10 mV by default. The rising threshold is `296 + 98*code`, which spans 2.96 V to 17.66 V. The falling threshold is 25 units (250 mV) below the rising threshold.

Top module: `ovp_supervisor`

## Requirements
- R1: After reset, `thr_reg` reads 0x000E, `fet_en`=1, `pg`=1, `alert_n`=1, and every status output reads zero.
- R2: The rising threshold is `296 + 98*code`, where `code` is `thr_reg[3:0]`. Bits 15:4 of `thr_reg` always read zero. The falling threshold is the rising threshold minus 25.
- R3: A sample with `sample_valid`=1 that is strictly greater than the rising threshold drives `fet_en` to 0 in the following cycle. A sample equal to the rising threshold does not.
- R4: While `fet_en`=0, the following leave `fet_en` at 0: a valid sample from the falling threshold up to any higher value, and any cycle with `sample_valid`=0. A valid sample strictly below the falling threshold sets `fet_en` to 1 in the following cycle.
- R5: A trip event is a valid sample above the rising threshold. In the cycle after a trip event, the following bits read 1:
  - `status_byte` bit 6 (switch off) and bit 0 (other);
  - `status_word_hi` bit 7 (output), bit 5 (input), bit 3 (power-good bad) and bit 0 (other);
  - `status_out` bit 5 (output undervoltage warning);
  - `status_input` bit 7 (input overvoltage fault);
  - `status_mfr2` bit 0 (power-good bad).
  
  All other status bits read 0.
- R6: The R5 bits stay set while the input recovers and while `fet_en` returns to 1. A `clear_faults` pulse with no trip event in the same cycle clears them in the following cycle.
- R7: If a trip event and `clear_faults` fall in the same cycle, the bits stay set. After a clear, the next trip event sets them again.
- R8: `alert_n` is 0 exactly when all of the following hold: the R5 bits are set, `gpio4_alert`=1, and `mask_input`, `mask_pgb` and `mask_out` are all 0. The mask and GPIO inputs act combinationally.
- R9: When `gpio1_pg`=1, `pg` equals `fet_en`. When `gpio1_pg`=0, `pg` is 1.
- R10: A write with `thr_wr_en`=1 and `wr_unlocked`=1 loads `wr_data[3:0]` into the code in the following cycle, and the new threshold governs later samples. A write with `wr_unlocked`=0 leaves `thr_reg` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_valid | input | 1 | `sample` holds a new conversion |
| sample | input | 12 | Input voltage, 10 mV per unit |
| thr_wr_en | input | 1 | Threshold register write strobe |
| wr_data | input | 16 | Threshold register write data |
| wr_unlocked | input | 1 | Write protection is lifted |
| clear_faults | input | 1 | Release the sticky status bits |
| mask_input | input | 1 | Alert mask for input status |
| mask_pgb | input | 1 | Alert mask for power-good bad |
| mask_out | input | 1 | Alert mask for output status |
| gpio1_pg | input | 1 | GPIO1 is configured as power-good |
| gpio4_alert | input | 1 | GPIO4 is configured as alert |
| thr_reg | output | 16 | Threshold register readback |
| fet_en | output | 1 | Power switch enable |
| alert_n | output | 1 | Active-low alert |
| pg | output | 1 | Power-good pin |
| status_byte | output | 8 | Summary status byte |
| status_word_hi | output | 8 | Upper byte of the status word |
| status_out | output | 8 | Output status |
| status_input | output | 8 | Input status |
| status_mfr2 | output | 8 | Secondary vendor status, low byte |

## Verification
The results are due at different times relative to a stimulus:
- `fet_en`, the status bits and `thr_reg` are registered. Each changes one cycle after the sample, clear or write that caused it.
- `alert_n` and `pg` also follow the mask and GPIO inputs within the same cycle.

The bench therefore drives inputs at the falling edge and advances its reference model at the rising edge. It compares every output at the next falling edge, so each result is checked in the first cycle it is due. Threshold boundaries (equal to the rising threshold, equal to the falling threshold) are covered, as are clear and trip in the same cycle.

// File: rtl/ovp_pkg.sv
package ovp_pkg;
   // Bit positions inside the status outputs
   localparam int SB_SW_OFF   = 6;
   localparam int SB_OTHER    = 0;
   localparam int SW_OUTPUT   = 7;
   localparam int SW_INPUT    = 5;
   localparam int SW_PGB      = 3;
   localparam int SW_OTHER    = 0;
   localparam int SO_UV_WARN  = 5;
   localparam int SI_OV_FAULT = 7;
   localparam int SM2_PGB     = 0;

   function automatic logic [7:0] bit_at(input int pos, input logic v);
      logic [7:0] r;
      r = '0;
      r[pos] = v;
      return r;
   endfunction
endpackage

// File: rtl/ovp_thr_reg.sv
module ovp_thr_reg #(
   parameter int REG_W    = 16,
   parameter int CODE_W   = 4,
   parameter int SAMPLE_W = 12,
   parameter int OFFSET   = 296,
   parameter int STEP     = 98,
   parameter int HYST     = 25,
   parameter int RST_CODE = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [REG_W-1:0]    wr_data,
   input  logic                unlocked,
   output logic [REG_W-1:0]    reg_out,
   output logic [SAMPLE_W-1:0] rise,
   output logic [SAMPLE_W-1:0] fall
);
   logic [CODE_W-1:0] code_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 code_q <= CODE_W'(RST_CODE);
      else if (wr_en && unlocked) code_q <= wr_data[CODE_W-1:0];
   end

   generate
      if (REG_W > CODE_W) begin : g_pad
         assign reg_out = {{(REG_W-CODE_W){1'b0}}, code_q};
      end else begin : g_exact
         assign reg_out = code_q;
      end
   endgenerate

   always_comb begin
      rise = SAMPLE_W'(OFFSET) + SAMPLE_W'(STEP) * SAMPLE_W'(code_q);
      fall = rise - SAMPLE_W'(HYST);
   end
endmodule

// File: rtl/ovp_hyst_det.sv
module ovp_hyst_det #(
   parameter int SAMPLE_W = 12
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                valid,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic [SAMPLE_W-1:0] rise,
   input  logic [SAMPLE_W-1:0] fall,
   output logic                trip,
   output logic                ov_q
);
   logic below;

   assign trip  = valid && (sample > rise);
   assign below = valid && (sample < fall);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ov_q <= 1'b0;
      else if (ov_q) ov_q <= !below;
      else           ov_q <= trip;
   end
endmodule

// File: rtl/ovp_status.sv
module ovp_status
   import ovp_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       trip,
   input  logic       clear,
   input  logic       ov_q,
   input  logic       mask_input,
   input  logic       mask_pgb,
   input  logic       mask_out,
   input  logic       gpio1_pg,
   input  logic       gpio4_alert,
   output logic       alert_n,
   output logic       pg,
   output logic [7:0] status_byte,
   output logic [7:0] status_word_hi,
   output logic [7:0] status_out,
   output logic [7:0] status_input,
   output logic [7:0] status_mfr2
);
   logic flag_q;

   // A new trip outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= trip | (flag_q & ~clear);
   end

   assign alert_n = ~(flag_q & gpio4_alert & ~(mask_input | mask_pgb | mask_out));
   assign pg      = gpio1_pg ? ~ov_q : 1'b1;

   always_comb begin
      status_byte    = bit_at(SB_SW_OFF, flag_q) | bit_at(SB_OTHER, flag_q);
      status_word_hi = bit_at(SW_OUTPUT, flag_q) | bit_at(SW_INPUT, flag_q)
                     | bit_at(SW_PGB, flag_q)    | bit_at(SW_OTHER, flag_q);
      status_out     = bit_at(SO_UV_WARN, flag_q);
      status_input   = bit_at(SI_OV_FAULT, flag_q);
      status_mfr2    = bit_at(SM2_PGB, flag_q);
   end
endmodule

// File: rtl/ovp_supervisor.sv
module ovp_supervisor #(
   parameter int REG_W    = 16,
   parameter int CODE_W   = 4,
   parameter int SAMPLE_W = 12,
   parameter int OFFSET   = 296,
   parameter int STEP     = 98,
   parameter int HYST     = 25,
   parameter int RST_CODE = 14
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                sample_valid,
   input  logic [SAMPLE_W-1:0] sample,
   input  logic                thr_wr_en,
   input  logic [REG_W-1:0]    wr_data,
   input  logic                wr_unlocked,
   input  logic                clear_faults,
   input  logic                mask_input,
   input  logic                mask_pgb,
   input  logic                mask_out,
   input  logic                gpio1_pg,
   input  logic                gpio4_alert,
   output logic [REG_W-1:0]    thr_reg,
   output logic                fet_en,
   output logic                alert_n,
   output logic                pg,
   output logic [7:0]          status_byte,
   output logic [7:0]          status_word_hi,
   output logic [7:0]          status_out,
   output logic [7:0]          status_input,
   output logic [7:0]          status_mfr2
);
   localparam int MAX_CODE = (1 << CODE_W) - 1;
   localparam int MAX_RISE = OFFSET + STEP * MAX_CODE;

   generate
      if (MAX_RISE >= (1 << SAMPLE_W)) begin : g_bad_range
         $error("ovp_supervisor: top threshold exceeds sample range");
      end
      if (HYST > OFFSET) begin : g_bad_hyst
         $error("ovp_supervisor: hysteresis larger than threshold offset");
      end
      if (REG_W < CODE_W || RST_CODE > MAX_CODE) begin : g_bad_code
         $error("ovp_supervisor: code does not fit register");
      end
   endgenerate

   logic [SAMPLE_W-1:0] rise, fall;
   logic                trip, ov_q;

   ovp_thr_reg #(
      .REG_W(REG_W), .CODE_W(CODE_W), .SAMPLE_W(SAMPLE_W), .OFFSET(OFFSET),
      .STEP(STEP), .HYST(HYST), .RST_CODE(RST_CODE)
   ) u_thr (
      .clk(clk), .rst_n(rst_n), .wr_en(thr_wr_en), .wr_data(wr_data),
      .unlocked(wr_unlocked), .reg_out(thr_reg), .rise(rise), .fall(fall)
   );

   ovp_hyst_det #(.SAMPLE_W(SAMPLE_W)) u_det (
      .clk(clk), .rst_n(rst_n), .valid(sample_valid), .sample(sample),
      .rise(rise), .fall(fall), .trip(trip), .ov_q(ov_q)
   );

   ovp_status u_stat (
      .clk(clk), .rst_n(rst_n), .trip(trip), .clear(clear_faults), .ov_q(ov_q),
      .mask_input(mask_input), .mask_pgb(mask_pgb), .mask_out(mask_out),
      .gpio1_pg(gpio1_pg), .gpio4_alert(gpio4_alert), .alert_n(alert_n), .pg(pg),
      .status_byte(status_byte), .status_word_hi(status_word_hi),
      .status_out(status_out), .status_input(status_input),
      .status_mfr2(status_mfr2)
   );

   assign fet_en = ~ov_q;
endmodule

// File: rtl/ovp_supervisor_chk.sv
module ovp_supervisor_chk #(
   parameter int REG_W    = 16,
   parameter int CODE_W   = 4,
   parameter int SAMPLE_W = 12,
   parameter int OFFSET   = 296,
   parameter int STEP     = 98,
   parameter int HYST     = 25
) (
   input logic                clk,
   input logic                rst_n,
   input logic                sample_valid,
   input logic [SAMPLE_W-1:0] sample,
   input logic                thr_wr_en,
   input logic                wr_unlocked,
   input logic                clear_faults,
   input logic                gpio1_pg,
   input logic                gpio4_alert,
   input logic [REG_W-1:0]    thr_reg,
   input logic                fet_en,
   input logic                alert_n,
   input logic                pg,
   input logic [7:0]          status_input
);
   int chk_rise, chk_fall;
   always_comb begin
      chk_rise = OFFSET + STEP * int'(thr_reg[CODE_W-1:0]);
      chk_fall = chk_rise - HYST;
   end

   assert_trip_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sample_valid && int'(sample) > chk_rise) |=> !fet_en);

   assert_band_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!fet_en && !(sample_valid && int'(sample) < chk_fall)) |=> !fet_en);

   assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (status_input[7] && !clear_faults) |=> status_input[7]);

   assert_alert_gpio_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !alert_n |-> (gpio4_alert && status_input[7]));

   assert_pg_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
      gpio1_pg |-> (pg == fet_en));

   assert_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (thr_wr_en && !wr_unlocked) |=> $stable(thr_reg));
endmodule

bind ovp_supervisor ovp_supervisor_chk #(
   .REG_W(REG_W), .CODE_W(CODE_W), .SAMPLE_W(SAMPLE_W),
   .OFFSET(OFFSET), .STEP(STEP), .HYST(HYST)
) u_chk (
   .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample(sample),
   .thr_wr_en(thr_wr_en), .wr_unlocked(wr_unlocked), .clear_faults(clear_faults),
   .gpio1_pg(gpio1_pg), .gpio4_alert(gpio4_alert), .thr_reg(thr_reg),
   .fet_en(fet_en), .alert_n(alert_n), .pg(pg), .status_input(status_input)
);

// File: tb/ovp_supervisor_bench.sv
`timescale 1ns/1ps
module ovp_supervisor_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sample_valid = 1'b0;
   logic [11:0] sample = '0;
   logic        thr_wr_en = 1'b0;
   logic [15:0] wr_data = '0;
   logic        wr_unlocked = 1'b0;
   logic        clear_faults = 1'b0;
   logic        mask_input = 1'b0, mask_pgb = 1'b0, mask_out = 1'b0;
   logic        gpio1_pg = 1'b1, gpio4_alert = 1'b1;
   logic [15:0] thr_reg;
   logic        fet_en, alert_n, pg;
   logic [7:0]  status_byte, status_word_hi, status_out, status_input, status_mfr2;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // Reference model state
   int  m_code = 14;
   bit  m_ov   = 1'b0;
   bit  m_flag = 1'b0;

   always #10 clk = ~clk;

   ovp_supervisor u_ovp_supervisor (
      .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample(sample),
      .thr_wr_en(thr_wr_en), .wr_data(wr_data), .wr_unlocked(wr_unlocked),
      .clear_faults(clear_faults), .mask_input(mask_input), .mask_pgb(mask_pgb),
      .mask_out(mask_out), .gpio1_pg(gpio1_pg), .gpio4_alert(gpio4_alert),
      .thr_reg(thr_reg), .fet_en(fet_en), .alert_n(alert_n), .pg(pg),
      .status_byte(status_byte), .status_word_hi(status_word_hi),
      .status_out(status_out), .status_input(status_input),
      .status_mfr2(status_mfr2)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic compare_all();
      bit al;
      al = m_flag && gpio4_alert && !(mask_input || mask_pgb || mask_out);
      check("R2/R10 thr_reg", int'(thr_reg), m_code);
      check("R3/R4 fet_en", int'(fet_en), int'(!m_ov));
      check("R5/R6 status_byte", int'(status_byte), m_flag ? 'h41 : 0);
      check("R5/R6 status_word_hi", int'(status_word_hi), m_flag ? 'hA9 : 0);
      check("R5 status_out", int'(status_out), m_flag ? 'h20 : 0);
      check("R5 status_input", int'(status_input), m_flag ? 'h80 : 0);
      check("R5 status_mfr2", int'(status_mfr2), m_flag ? 'h01 : 0);
      check("R8 alert_n", int'(alert_n), int'(!al));
      check("R9 pg", int'(pg), gpio1_pg ? int'(!m_ov) : 1);
   endtask

   // One clock: model advances with the inputs held across the edge
   task automatic tick();
      int rise, fall;
      bit trip, below;
      @(posedge clk);
      rise  = 296 + 98 * m_code;
      fall  = rise - 25;
      trip  = sample_valid && int'(sample) > rise;
      below = sample_valid && int'(sample) < fall;
      m_flag = trip || (m_flag && !clear_faults);
      m_ov   = m_ov ? !below : trip;
      if (thr_wr_en && wr_unlocked) m_code = int'(wr_data[3:0]);
      @(negedge clk);
      compare_all();
   endtask

   task automatic drive_sample(input int v);
      sample_valid = 1'b1;
      sample = 12'(v);
      tick();
      sample_valid = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 20);
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 thr_reg", int'(thr_reg), 'h000E);
      check("R1 fet_en", int'(fet_en), 1);
      check("R1 alert_n", int'(alert_n), 1);
      check("R1 pg", int'(pg), 1);
      check("R1 status", int'(status_byte | status_word_hi | status_input), 0);
      rst_n = 1'b1;
      tick();

      // R3: rising threshold at code 14 is 1668
      drive_sample(1000);
      drive_sample(1668);
      check("R3 equal no trip", int'(fet_en), 1);
      drive_sample(1669);
      check("R3 trip", int'(fet_en), 0);
      check("R5 status_input", int'(status_input), 'h80);
      check("R8 alert asserted", int'(alert_n), 0);

      // R4: falling threshold 1643; band and idle cycles hold
      drive_sample(1643);
      check("R4 at fall holds", int'(fet_en), 0);
      drive_sample(1700);
      sample = 12'd0;
      tick();
      check("R4 idle holds", int'(fet_en), 0);
      drive_sample(1642);
      check("R4 restore", int'(fet_en), 1);
      check("R6 sticky after restore", int'(status_word_hi), 'hA9);

      // R8: masks and GPIO selection, combinational
      mask_pgb = 1'b1; #1 check("R8 masked", int'(alert_n), 1); mask_pgb = 1'b0;
      gpio4_alert = 1'b0; #1 check("R8 gpio4 off", int'(alert_n), 1); gpio4_alert = 1'b1;
      tick();

      // R6: clear
      clear_faults = 1'b1; tick(); clear_faults = 1'b0;
      check("R6 cleared", int'(status_byte), 0);
      check("R6 alert released", int'(alert_n), 1);

      // R7: clear with trip in same cycle keeps flags
      clear_faults = 1'b1;
      drive_sample(2000);
      clear_faults = 1'b0;
      check("R7 set wins", int'(status_input), 'h80);
      clear_faults = 1'b1;
      drive_sample(1650);
      clear_faults = 1'b0;
      check("R7 band clear", int'(status_input), 0);
      drive_sample(1669);
      check("R7 retrip", int'(status_mfr2), 1);

      // R9: pg with GPIO1 not configured
      gpio1_pg = 1'b0; #1 check("R9 pg unused", int'(pg), 1);
      gpio1_pg = 1'b1; #1 check("R9 pg low", int'(pg), 0);
      drive_sample(100);
      clear_faults = 1'b1; tick(); clear_faults = 1'b0;

      // R10: locked write ignored, unlocked write takes effect
      thr_wr_en = 1'b1; wr_data = 16'h0005; wr_unlocked = 1'b0;
      tick();
      check("R10 locked", int'(thr_reg), 'h000E);
      wr_data = 16'hFFF3; wr_unlocked = 1'b1;
      tick();
      thr_wr_en = 1'b0; wr_unlocked = 1'b0;
      check("R2 upper bits zero", int'(thr_reg), 'h0003);
      drive_sample(590);
      check("R2 new rise equal", int'(fet_en), 1);
      drive_sample(591);
      check("R2 new rise trip", int'(fet_en), 0);
      drive_sample(565);
      check("R2 new fall holds", int'(fet_en), 0);
      drive_sample(564);
      check("R2 new fall restore", int'(fet_en), 1);

      // Mixed sweep against the model
      for (int i = 0; i < 400; i++) begin
         sample_valid = ($urandom_range(0, 3) != 0);
         sample       = 12'($urandom_range(400, 1900));
         clear_faults = ($urandom_range(0, 15) == 0);
         mask_input   = ($urandom_range(0, 7) == 0);
         gpio1_pg     = ($urandom_range(0, 7) != 0);
         thr_wr_en    = ($urandom_range(0, 31) == 0);
         wr_data      = 16'($urandom);
         wr_unlocked  = $urandom_range(0, 1) == 1;
         tick();
      end
      finish_run();
   end
endmodule